// File: doc/BRIEF.md
# Two-Way Write-Back Cache Controller

This block sits between a 32-bit processor request port and a single-beat memory master port. It holds 8 kB in two ways of 32-byte lines and serves instructions and data from the same store. A read that hits returns data in the cycle it is presented. A read that misses stalls the processor while the controller refills the whole eight-word line. If the chosen victim is dirty, its eight words are written out first. A write that hits updates the stored word in the same cycle and marks the line dirty. A write that misses is forwarded to memory as a single transfer and never allocates a line.

Caching is gated twice. The bottom 32 MB of the address space is divided into sixteen 2 MB pages, each with its own enable bit. A two-bit mode input decides whether instruction fetches, data accesses, both or neither may be cached. Anything not eligible passes straight through to memory as one transfer. Such an access pays one extra cycle for the lookup.

The processor holds a request stable, including its address, data and type, until it sees `cpu_ready` high at a rising edge. The controller is a four-state machine:

- `ST_IDLE` looks up the request. It stays put on a hit. It goes to `ST_BYPASS` for an ineligible access or a write miss. It goes to `ST_FLUSH` for a read miss with a dirty victim, and to `ST_FILL` for a read miss with a clean or invalid victim.
- `ST_BYPASS` returns to `ST_IDLE` when its single transfer completes.
- `ST_FLUSH` moves to `ST_FILL` after its eighth write beat.
- `ST_FILL` returns to `ST_IDLE` after its eighth read beat. There the held request hits.

Top module: `wbcache_top`

## Requirements
- R1: After reset every line is invalid, so the first read of any cacheable address produces a refill on the memory port.
- R2: A cacheable read miss stalls the processor and issues eight read beats at the line base, ascending word offset 0 to 7 (address bits [4:2]); the held read then returns the stored word.
- R3: A cacheable read hit raises `cpu_ready` in the cycle the request is presented, with no memory traffic.
- R4: A cacheable write hit completes in the cycle it is presented, issues no memory traffic and leaves memory unchanged, while later reads return the new value.
- R5: A cacheable write miss issues exactly one memory write to the request address and allocates no line, so a following read of that address refills.
- R6: A read miss whose victim is dirty first writes the victim's eight words to its own line addresses in ascending order, then performs the eight-beat refill.
- R7: The set index is address bits [11:5] and each set has two ways; an invalid way is filled first, otherwise the least recently used way (updated on every hit and fill) is replaced.
- R8: An access is cacheable only if address bits [31:25] are zero and `cfg_page_en[addr[24:21]]` is 1; otherwise it passes through as one transfer.
- R9: `cfg_mode` encodes 2'b00 no caching, 2'b01 instruction fetches only, 2'b10 data accesses only, 2'b11 both; `cpu_instr` high marks a fetch.
- R10: A pass-through access issues its memory transfer one cycle after it is presented, so it completes with one wait state more than the memory's own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Access-type eligibility mode (R9) |
| cfg_page_en | input | 16 | One enable per 2 MB page of the bottom 32 MB |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_instr | input | 1 | 1 for an instruction fetch |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes at this rising edge |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| mem_valid | output | 1 | Memory transfer request |
| mem_write | output | 1 | 1 for a memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Current beat completes at this rising edge |
| mem_rdata | input | 32 | Memory read data |

## Verification
In one cycle, a write hit sets the dirty flag of one way and moves that set's recency bit to the other way. A later miss in the same set must then pick the correct victim and decide correctly whether to flush it. The bench provokes this with a miss, a second miss, a dirtying write and reads to both ways of one set. It then sends a third tag to that set and looks at the memory log. The victim's eight write beats at its old line addresses must come before the eight refill reads. Memory must now hold the value written earlier, and that value never appeared on the bus at write time.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BYPASS,
        ST_FLUSH,
        ST_FILL
    } wbc_state_e;

    typedef enum logic [1:0] {
        MODE_NONE    = 2'b00,
        MODE_INSTR   = 2'b01,
        MODE_DATA    = 2'b10,
        MODE_UNIFIED = 2'b11
    } wbc_mode_e;
endpackage

// File: rtl/wbc_gate.sv
module wbc_gate
    import wbc_pkg::*;
#(
    parameter int PAGE_COUNT = 16,
    parameter int PAGE_SHIFT = 21
) (
    input  logic [31:PAGE_SHIFT]  addr_hi,
    input  logic                  instr,
    input  logic [1:0]            mode,
    input  logic [PAGE_COUNT-1:0] page_en,
    output logic                  cacheable
);
    localparam int PIDX_BITS  = $clog2(PAGE_COUNT);
    localparam int REGION_TOP = PAGE_SHIFT + PIDX_BITS;

    logic [PIDX_BITS-1:0] page;
    logic                 in_region;
    logic                 type_ok;

    assign page      = addr_hi[REGION_TOP-1:PAGE_SHIFT];
    assign in_region = (addr_hi[31:REGION_TOP] == '0);

    always_comb begin
        unique case (mode)
            MODE_INSTR:   type_ok = instr;
            MODE_DATA:    type_ok = !instr;
            MODE_UNIFIED: type_ok = 1'b1;
            default:      type_ok = 1'b0;
        endcase
    end

    assign cacheable = in_region && page_en[page] && type_ok;
endmodule

// File: rtl/wbc_tags.sv
module wbc_tags #(
    parameter int SETS     = 128,
    parameter int TAG_BITS = 20,
    localparam int SET_BITS = $clog2(SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_BITS-1:0] set_idx,
    input  logic [TAG_BITS-1:0] look_tag,
    input  logic                touch_en,
    input  logic                touch_way,
    input  logic                mark_dirty,
    input  logic                install_en,
    input  logic                install_way,
    input  logic [TAG_BITS-1:0] install_tag,
    output logic                hit_any,
    output logic                hit_way,
    output logic                victim_way,
    output logic                victim_dirty,
    output logic [TAG_BITS-1:0] victim_tag
);
    logic [1:0]          way_valid;
    logic [1:0]          way_dirty;
    logic [1:0]          way_hit;
    logic [TAG_BITS-1:0] way_tag [2];
    logic [SETS-1:0]     lru_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        localparam logic WAY_ID = 1'(w);
        logic [SETS-1:0]     valid_q;
        logic [SETS-1:0]     dirty_q;
        logic [TAG_BITS-1:0] tag_q [SETS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else if (install_en && install_way == WAY_ID) begin
                valid_q[set_idx] <= 1'b1;
                dirty_q[set_idx] <= 1'b0;
            end else if (touch_en && mark_dirty && touch_way == WAY_ID) begin
                dirty_q[set_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (install_en && install_way == WAY_ID) begin
                tag_q[set_idx] <= install_tag;
            end
        end

        assign way_valid[w] = valid_q[set_idx];
        assign way_dirty[w] = dirty_q[set_idx];
        assign way_tag[w]   = tag_q[set_idx];
        assign way_hit[w]   = valid_q[set_idx] && (tag_q[set_idx] == look_tag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (install_en) begin
            lru_q[set_idx] <= ~install_way;
        end else if (touch_en) begin
            lru_q[set_idx] <= ~touch_way;
        end
    end

    always_comb begin
        if (!way_valid[0])      victim_way = 1'b0;
        else if (!way_valid[1]) victim_way = 1'b1;
        else                    victim_way = lru_q[set_idx];
    end

    assign hit_any      = |way_hit;
    assign hit_way      = way_hit[1];
    assign victim_dirty = way_dirty[victim_way];
    assign victim_tag   = way_tag[victim_way];

    // Both ways of a set never match the same tag.
    assert_single_way_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // A fill never targets a way that holds a different valid line that is also dirty.
    assert_install_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        install_en |=> !way_dirty[$past(install_way)] || ($past(set_idx) != set_idx));
endmodule

// File: rtl/wbc_data.sv
module wbc_data #(
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 8,
    localparam int IDX_BITS  = 1 + $clog2(SETS) + $clog2(LINE_WORDS)
) (
    input  logic                clk,
    input  logic                we,
    input  logic [IDX_BITS-1:0] waddr,
    input  logic [31:0]         wdata,
    input  logic [IDX_BITS-1:0] raddr,
    output logic [31:0]         rdata
);
    logic [31:0] store_q [2**IDX_BITS];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/wbcache_top.sv
module wbcache_top
    import wbc_pkg::*;
#(
    parameter int CACHE_BYTES = 8192,
    parameter int LINE_WORDS  = 8,
    parameter int PAGE_COUNT  = 16,
    parameter int PAGE_SHIFT  = 21
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cfg_mode,
    input  logic [PAGE_COUNT-1:0] cfg_page_en,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic                  cpu_instr,
    input  logic [31:0]           cpu_addr,
    input  logic [31:0]           cpu_wdata,
    output logic                  cpu_ready,
    output logic [31:0]           cpu_rdata,
    output logic                  mem_valid,
    output logic                  mem_write,
    output logic [31:0]           mem_addr,
    output logic [31:0]           mem_wdata,
    input  logic                  mem_ready,
    input  logic [31:0]           mem_rdata
);
    localparam int WORD_BITS = $clog2(LINE_WORDS);
    localparam int OFF_BITS  = WORD_BITS + 2;
    localparam int SETS      = CACHE_BYTES / (2 * LINE_WORDS * 4);
    localparam int SET_BITS  = $clog2(SETS);
    localparam int TAG_BITS  = 32 - SET_BITS - OFF_BITS;
    localparam int SET_LO    = OFF_BITS;
    localparam int SET_HI    = OFF_BITS + SET_BITS - 1;
    localparam int IDX_BITS  = 1 + SET_BITS + WORD_BITS;
    localparam logic [WORD_BITS-1:0] BEAT_LAST = WORD_BITS'(LINE_WORDS - 1);

    wbc_state_e state_q, state_d;

    logic [31:0]          lat_addr_q;
    logic [31:0]          lat_wdata_q;
    logic                 lat_we_q;
    logic                 vic_way_q;
    logic [TAG_BITS-1:0]  vic_tag_q;
    logic [WORD_BITS-1:0] beat_q;
    logic                 latch, beat_inc;

    logic [SET_BITS-1:0]  set_cur;
    logic                 eligible;
    logic                 hit_any, hit_way, victim_way, victim_dirty;
    logic [TAG_BITS-1:0]  victim_tag;
    logic                 touch_en, mark_dirty, install_en;
    logic                 dat_we;
    logic [IDX_BITS-1:0]  dat_waddr, dat_raddr;
    logic [31:0]          dat_wdata, dat_rdata;

    assign set_cur = (state_q == ST_IDLE) ? cpu_addr[SET_HI:SET_LO]
                                          : lat_addr_q[SET_HI:SET_LO];

    wbc_gate #(.PAGE_COUNT(PAGE_COUNT), .PAGE_SHIFT(PAGE_SHIFT)) u_gate (
        .addr_hi   (cpu_addr[31:PAGE_SHIFT]),
        .instr     (cpu_instr),
        .mode      (cfg_mode),
        .page_en   (cfg_page_en),
        .cacheable (eligible)
    );

    wbc_tags #(.SETS(SETS), .TAG_BITS(TAG_BITS)) u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_idx      (set_cur),
        .look_tag     (cpu_addr[31:32-TAG_BITS]),
        .touch_en     (touch_en),
        .touch_way    (hit_way),
        .mark_dirty   (mark_dirty),
        .install_en   (install_en),
        .install_way  (vic_way_q),
        .install_tag  (lat_addr_q[31:32-TAG_BITS]),
        .hit_any      (hit_any),
        .hit_way      (hit_way),
        .victim_way   (victim_way),
        .victim_dirty (victim_dirty),
        .victim_tag   (victim_tag)
    );

    wbc_data #(.SETS(SETS), .LINE_WORDS(LINE_WORDS)) u_data (
        .clk   (clk),
        .we    (dat_we),
        .waddr (dat_waddr),
        .wdata (dat_wdata),
        .raddr (dat_raddr),
        .rdata (dat_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request and burst bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr_q  <= '0;
            lat_wdata_q <= '0;
            lat_we_q    <= 1'b0;
            vic_way_q   <= 1'b0;
            vic_tag_q   <= '0;
            beat_q      <= '0;
        end else if (latch) begin
            lat_addr_q  <= cpu_addr;
            lat_wdata_q <= cpu_wdata;
            lat_we_q    <= cpu_we;
            vic_way_q   <= victim_way;
            vic_tag_q   <= victim_tag;
            beat_q      <= '0;
        end else if (beat_inc) begin
            beat_q      <= beat_q + WORD_BITS'(1);
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        latch      = 1'b0;
        beat_inc   = 1'b0;
        cpu_ready  = 1'b0;
        cpu_rdata  = dat_rdata;
        mem_valid  = 1'b0;
        mem_write  = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        touch_en   = 1'b0;
        mark_dirty = 1'b0;
        install_en = 1'b0;
        dat_we     = 1'b0;
        dat_wdata  = cpu_wdata;
        dat_raddr  = {hit_way, set_cur, cpu_addr[SET_LO-1:2]};
        dat_waddr  = {hit_way, set_cur, cpu_addr[SET_LO-1:2]};
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (eligible && hit_any) begin
                        cpu_ready  = 1'b1;
                        touch_en   = 1'b1;
                        mark_dirty = cpu_we;
                        dat_we     = cpu_we;
                    end else begin
                        latch = 1'b1;
                        if (eligible && !cpu_we)
                            state_d = victim_dirty ? ST_FLUSH : ST_FILL;
                        else
                            state_d = ST_BYPASS;
                    end
                end
            end
            ST_BYPASS: begin
                mem_valid = 1'b1;
                mem_write = lat_we_q;
                mem_addr  = lat_addr_q;
                mem_wdata = lat_wdata_q;
                if (mem_ready) begin
                    cpu_ready = 1'b1;
                    cpu_rdata = mem_rdata;
                    state_d   = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                dat_raddr = {vic_way_q, set_cur, beat_q};
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {vic_tag_q, set_cur, beat_q, 2'b00};
                mem_wdata = dat_rdata;
                if (mem_ready) begin
                    beat_inc = 1'b1;
                    if (beat_q == BEAT_LAST) state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {lat_addr_q[31:SET_LO], beat_q, 2'b00};
                dat_waddr = {vic_way_q, set_cur, beat_q};
                dat_wdata = mem_rdata;
                if (mem_ready) begin
                    dat_we   = 1'b1;
                    beat_inc = 1'b1;
                    if (beat_q == BEAT_LAST) begin
                        install_en = 1'b1;
                        state_d    = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // The lookup cycle never drives the memory port.
    assert_idle_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !mem_valid);

    // Refill beats walk the line in ascending word order.
    assert_fill_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_ready && mem_addr[SET_LO-1:2] != BEAT_LAST)
        |=> mem_addr[SET_LO-1:2] == $past(mem_addr[SET_LO-1:2]) + WORD_BITS'(1));

    // A write that misses never starts a refill.
    assert_wmiss_bypasses_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && cpu_we && !hit_any) |=> (state_q == ST_BYPASS));

    // A flush can only be followed by its refill.
    assert_flush_then_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (state_q == ST_FLUSH || state_q == ST_FILL));
endmodule

// File: tb/sim_wbcache_top.sv
module sim_wbcache_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b11;
    logic [15:0] cfg_page_en = 16'hFFFF;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_instr = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    wbcache_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_page_en(cfg_page_en),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_instr(cpu_instr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Memory model and reference image
    logic [31:0] bmem [logic [31:0]];
    logic [31:0] rmem [logic [31:0]];
    bit          log_we [$];
    logic [31:0] log_addr [$];

    function automatic logic [31:0] seed(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
    endfunction
    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return bmem.exists(a) ? bmem[a] : seed(a);
    endfunction
    function automatic logic [31:0] ref_rd(input logic [31:0] a);
        return rmem.exists(a) ? rmem[a] : seed(a);
    endfunction

    always @(negedge clk) begin
        if (mem_ready) mem_ready = 1'b0;
        else if (mem_valid) begin
            mem_ready = 1'b1;
            mem_rdata = mem_rd(mem_addr);
        end
    end

    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            log_we.push_back(mem_write);
            log_addr.push_back(mem_addr);
            if (mem_write) bmem[mem_addr] = mem_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always begin
        @(negedge clk);
        #4;
        if (cpu_req && cpu_ready && !cpu_we) begin
            if (exp_q.size() == 0) check(1'b0, "read without expectation", cpu_rdata, 32'h0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(cpu_rdata === e, t, cpu_rdata, e);
            end
        end
    end

    task automatic access(input logic [31:0] a, input bit we, input bit ins,
                          input logic [31:0] d, input string tag, output int waits);
        log_we.delete();
        log_addr.delete();
        if (!we) begin
            exp_q.push_back(ref_rd(a));
            tag_q.push_back(tag);
        end else rmem[a] = d;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_instr = ins; cpu_addr = a; cpu_wdata = d;
        waits = 0;
        #4;
        while (!cpu_ready) begin
            waits++;
            @(negedge clk);
            #4;
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic check_burst(input int first, input bit we, input logic [31:0] base, input string req);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] ea;
            ea = base + 32'(4 * i);
            check(log_we[first+i] == we && log_addr[first+i] == ea, req, log_addr[first+i], ea);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w;
        localparam logic [31:0] A = 32'h0000_1040, B = 32'h0000_2040, C = 32'h0000_3040;
        localparam logic [31:0] D = 32'h0000_5000, E = 32'h0000_4040, F = 32'h0000_6080;
        localparam logic [31:0] X = 32'h00A0_0040, Y = 32'h0200_0100;
        repeat (3) @(negedge clk);
        check(!mem_valid && !cpu_ready, "R1 reset quiet", {30'd0, mem_valid, cpu_ready}, 32'h0);
        rst_n = 1'b1;

        // R1/R2 first read misses and refills in order
        access(A, 0, 0, 0, "R2 fill data", w);
        check(log_we.size() == 8, "R1 first read refills", log_we.size(), 8);
        check_burst(0, 0, A, "R2 ascending refill");
        // R3 read hit
        access(A + 4, 0, 0, 0, "R3 hit data", w);
        check(w == 0, "R3 zero wait", w, 0);
        check(log_we.size() == 0, "R3 no bus", log_we.size(), 0);
        // R4 write hit
        access(A + 8, 1, 0, 32'hDEAD_BEEF, "", w);
        check(w == 0, "R4 zero wait", w, 0);
        check(log_we.size() == 0, "R4 no bus", log_we.size(), 0);
        check(mem_rd(A + 8) == seed(A + 8), "R4 memory untouched", mem_rd(A + 8), seed(A + 8));
        access(A + 8, 0, 0, 0, "R4 read new value", w);
        check(w == 0, "R4 read back hits", w, 0);
        // R5 write miss
        access(D, 1, 0, 32'h1234_5678, "", w);
        check(log_we.size() == 1 && log_we[0] && log_addr[0] == D, "R5 single write", log_addr[0], D);
        check(mem_rd(D) == 32'h1234_5678, "R5 memory written", mem_rd(D), 32'h1234_5678);
        check(w == 1, "R10 write pass-through wait", w, 1);
        access(D, 0, 0, 0, "R5 read after miss", w);
        check(log_we.size() == 8, "R5 no allocation", log_we.size(), 8);
        // R7 replacement
        access(B, 0, 0, 0, "R7 fill B", w);
        check(log_we.size() == 8 && !log_we[0], "R7 invalid way used", log_we.size(), 8);
        access(B, 0, 0, 0, "R7 B hit", w);
        check(w == 0, "R7 B resident", w, 0);
        access(A, 0, 0, 0, "R7 A hit", w);
        check(w == 0, "R7 A resident", w, 0);
        access(C, 0, 0, 0, "R7 fill C", w);
        check(log_we.size() == 8 && !log_we[0], "R7 clean LRU victim", log_we.size(), 8);
        access(A, 0, 0, 0, "R7 A kept", w);
        check(w == 0 && log_we.size() == 0, "R7 A not evicted", w, 0);
        access(C, 0, 0, 0, "R7 C hit", w);
        check(w == 0, "R7 C resident", w, 0);
        // R6 dirty eviction
        access(E, 0, 0, 0, "R6 fill after flush", w);
        check(log_we.size() == 16, "R6 sixteen beats", log_we.size(), 16);
        if (log_we.size() == 16) begin
            check_burst(0, 1, A, "R6 flush first");
            check_burst(8, 0, E, "R6 refill after flush");
        end
        check(mem_rd(A + 8) == 32'hDEAD_BEEF, "R6 dirty word written", mem_rd(A + 8), 32'hDEAD_BEEF);
        // R8 page gating
        cfg_page_en = 16'hFFFE;
        access(A + 8, 0, 0, 0, "R8 disabled page data", w);
        check(log_we.size() == 1, "R8 page 0 bypass", log_we.size(), 1);
        check(w == 1, "R10 read pass-through wait", w, 1);
        cfg_page_en = 16'hFFDF;
        access(X, 0, 0, 0, "R8 page 5 off", w);
        check(log_we.size() == 1, "R8 page 5 bypass", log_we.size(), 1);
        cfg_page_en = 16'hFFFF;
        access(X, 0, 0, 0, "R8 page 5 on", w);
        check(log_we.size() == 8, "R8 page 5 cached", log_we.size(), 8);
        access(Y, 0, 0, 0, "R8 above region", w);
        check(log_we.size() == 1, "R8 above 32 MB bypass", log_we.size(), 1);
        // R9 modes
        cfg_mode = 2'b01;
        access(F, 0, 0, 0, "R9 data in instr mode", w);
        check(log_we.size() == 1, "R9 data bypass", log_we.size(), 1);
        access(F, 0, 1, 0, "R9 instr fill", w);
        check(log_we.size() == 8, "R9 instr cached", log_we.size(), 8);
        cfg_mode = 2'b10;
        access(F, 0, 1, 0, "R9 instr in data mode", w);
        check(log_we.size() == 1, "R9 instr bypass", log_we.size(), 1);
        access(F, 0, 0, 0, "R9 data hit", w);
        check(log_we.size() == 0 && w == 0, "R9 data cached", log_we.size(), 0);
        cfg_mode = 2'b00;
        access(F, 0, 0, 0, "R9 none mode", w);
        check(log_we.size() == 1, "R9 nothing cached", log_we.size(), 1);
        cfg_mode = 2'b11;

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule